// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

This block collects a small set of level-sensitive interrupt request lines into a sticky pending register. Each pending bit is gated by a software-programmed mask. A fixed-priority encoder picks the winning source from the gated set, and the lowest index has the highest priority. A status flip-flop records whether any gated request exists. A global enable flip-flop decides whether that condition reaches the processor as a single interrupt line.

When the processor acknowledges, the controller drives a vector onto the data bus and clears the global enable, so no second interrupt is raised before software is ready for it. The vector is the winning source index in the low bits, with zeros above. The service routine uses a simple write port for three tasks: it clears the pending bit of the source it served, it rewrites the mask to block or restore lower-priority sources, and it sets the enable again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, with no other activity, `irq_o` is 0, `vec_oe_o` is 0 and `vec_o` is 0. The pending bits, the mask bits, the enable and the status all reset to 0.
- R2: A request input that is high at a rising clock edge sets its pending bit. The bit stays set after the request falls, until software clears it.
- R3: A pending source whose mask bit is 0 neither raises `irq_o` nor is selected as the vector.
- R4: Among pending sources whose mask bit is 1, the source with the lowest index wins. Index 0 has the highest priority.
- R5: The status flag is registered from the masked pending set, one clock after that set changes. `irq_o` is the AND of the status flag and the enable flag.
- R6: `vec_oe_o` equals `ack_i`. While `ack_i` is 1, `vec_o` carries the winning index zero-extended, or 0 if no masked source is pending. While `ack_i` is 0, `vec_o` is 0.
- R7: `ack_i` high at a clock edge clears the enable flag. This takes priority over a software enable write in the same cycle.
- R8: A write with `wr_sel_i`=1 loads `wr_data_i[0]` into the enable flag.
- R9: A write with `wr_sel_i`=2 clears every pending bit whose `wr_data_i` bit is 1. A request input that is high in the same cycle keeps its bit set.
- R10: A write with `wr_sel_i`=0 loads `wr_data_i` into the mask register. A write with `wr_sel_i`=3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Level-sensitive interrupt requests |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 enable, 2 pending clear, 3 none |
| wr_data_i | input | N_SRC | Write data |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | DATA_W | Vector address for the data bus |
| vec_oe_o | output | 1 | Data bus drive enable |

## Verification
A corrupted pending or mask bit has two visible effects. It shows at the ports as a wrong vector on the next acknowledge. It also shows as a wrong `irq_o` level one clock after the bit goes wrong, because the status flag samples the masked set every cycle. A stuck enable flag shows as `irq_o` staying high in the cycle after an acknowledge. The bench runs a behavioural model beside the design and compares all outputs every cycle. Stray state therefore surfaces within one or two clocks of its cause, during directed sequences and during a long pseudo-random stretch.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    WR_MASK = 2'd0,
    WR_IEN  = 2'd1,
    WR_CLR  = 2'd2,
    WR_NOP  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  // a held request wins over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | req_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC  = 4,
  parameter int CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]  vld_i,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N_SRC:0]   blk;
  logic [N_SRC-1:0] win;

  assign blk[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_chain
    assign win[g]   = vld_i[g] & ~blk[g];
    assign blk[g+1] = blk[g] | vld_i[g];
  end

  assign any_o = blk[N_SRC];

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (win[i]) code_o = code_o | CODE_W'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic             ien_we_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic             ack_i,
  input  logic             any_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             ien_o,
  output logic             ist_o
);
  logic [N_SRC-1:0] mask_q;
  logic             ien_q, ist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ien_q  <= 1'b0;
      ist_q  <= 1'b0;
    end else begin
      ist_q <= any_i;
      if (mask_we_i) mask_q <= wdata_i;
      if (ack_i)         ien_q <= 1'b0;
      else if (ien_we_i) ien_q <= wdata_i[0];
    end
  end

  assign mask_o = mask_q;
  assign ien_o  = ien_q;
  assign ist_o  = ist_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_oe_o
);
  localparam int CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  wr_sel_e          sel;
  logic             mask_we, ien_we;
  logic [N_SRC-1:0] clr, pend_q, mask_q, masked;
  logic             any, ien_q, ist_q;
  logic [CODE_W-1:0] code;

  assign sel     = wr_sel_e'(wr_sel_i);
  assign mask_we = wr_en_i && (sel == WR_MASK);
  assign ien_we  = wr_en_i && (sel == WR_IEN);
  assign clr     = (wr_en_i && (sel == WR_CLR)) ? wr_data_i : '0;

  irq_pend_reg #(.N_SRC(N_SRC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .clr_i (clr),
    .pend_o(pend_q)
  );

  assign masked = pend_q & mask_q;

  irq_prio_enc #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_enc (
    .vld_i (masked),
    .any_o (any),
    .code_o(code)
  );

  irq_ctrl_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(mask_we),
    .ien_we_i (ien_we),
    .wdata_i  (wr_data_i),
    .ack_i    (ack_i),
    .any_i    (any),
    .mask_o   (mask_q),
    .ien_o    (ien_q),
    .ist_o    (ist_q)
  );

  assign irq_o    = ist_q & ien_q;
  assign vec_oe_o = ack_i;
  assign vec_o    = ack_i ? {{(DATA_W-CODE_W){1'b0}}, code} : '0;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 8,
  parameter int CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  req_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] vec_o,
  input logic [N_SRC-1:0]  pend_i,
  input logic [N_SRC-1:0]  mask_i
);
  logic [N_SRC-1:0]  gated;
  logic [CODE_W-1:0] vcode;
  assign gated = pend_i & mask_i;
  assign vcode = vec_o[CODE_W-1:0];

  assert_req_latched_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & $past(req_i)) == $past(req_i)));

  assert_vec_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (gated != '0)) |-> gated[vcode]);

  assert_vec_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (gated != '0)) |->
      ((gated & ((N_SRC'(1) << vcode) - N_SRC'(1))) == '0));

  assert_irq_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(gated) != '0));

  assert_bus_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |-> (vec_o == '0));

  assert_ack_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .ack_i (ack_i),
  .irq_o (irq_o),
  .vec_o (vec_o),
  .pend_i(pend_q),
  .mask_i(mask_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int N_SRC  = 4;
  localparam int DATA_W = 8;
  localparam int CLK_PERIOD = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_SRC-1:0]  req_i = '0;
  logic              wr_en_i = 1'b0;
  logic [1:0]        wr_sel_i = 2'd3;
  logic [N_SRC-1:0]  wr_data_i = '0;
  logic              ack_i = 1'b0;
  logic              irq_o;
  logic [DATA_W-1:0] vec_o;
  logic              vec_oe_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_pend = 0, m_mask = 0, m_ien = 0, m_ist = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prio_irq_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_prio_irq_ctrl (.*);

  function automatic int exp_vec();
    int g = m_pend & m_mask;
    for (int i = 0; i < N_SRC; i++) if ((g >> i) & 1) return i;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "irq_o", int'(irq_o), m_ist & m_ien);
    chk(tag, "vec_oe_o", int'(vec_oe_o), int'(ack_i));
    chk(tag, "vec_o", int'(vec_o), ack_i ? exp_vec() : 0);
  endtask

  task automatic model_edge();
    int nxt_ist = ((m_pend & m_mask) != 0) ? 1 : 0;
    if (wr_en_i && wr_sel_i == 2'd2) m_pend = m_pend & ~int'(wr_data_i);
    m_pend = m_pend | int'(req_i);
    if (wr_en_i && wr_sel_i == 2'd0) m_mask = int'(wr_data_i);
    if (ack_i) m_ien = 0;
    else if (wr_en_i && wr_sel_i == 2'd1) m_ien = int'(wr_data_i[0]);
    m_ist = nxt_ist;
  endtask

  // inputs are set at negedge; outputs compared 1 time unit later
  task automatic cyc(string tag, logic [N_SRC-1:0] req, logic we, logic [1:0] sel,
                     logic [N_SRC-1:0] d, logic ack);
    req_i = req; wr_en_i = we; wr_sel_i = sel; wr_data_i = d; ack_i = ack;
    #1;
    compare(tag);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) cyc(tag, '0, 1'b0, 2'd3, '0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    // R1 reset
    @(negedge clk_i);
    #1 compare("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R1", 2);

    // R2/R3: pulse on source 2 while masked
    cyc("R2", 4'b0100, 1'b0, 2'd3, '0, 1'b0);
    cyc("R3", '0, 1'b1, 2'd1, 4'b0001, 1'b0);   // R8 enable on
    idle("R3", 3);
    cyc("R3", '0, 1'b0, 2'd3, '0, 1'b1);        // ack with nothing unmasked
    cyc("R8", '0, 1'b1, 2'd1, 4'b0001, 1'b0);
    cyc("R10", '0, 1'b1, 2'd0, 4'b1111, 1'b0);  // unmask all
    idle("R5", 2);
    cyc("R6", '0, 1'b0, 2'd3, '0, 1'b1);        // vector 2, enable drops
    idle("R7", 2);

    // R4: sources 1 and 3 join pending 2
    cyc("R4", 4'b1010, 1'b0, 2'd3, '0, 1'b0);
    cyc("R4", '0, 1'b0, 2'd3, '0, 1'b1);
    cyc("R9", '0, 1'b1, 2'd2, 4'b0010, 1'b0);   // clear served source 1
    cyc("R4", '0, 1'b0, 2'd3, '0, 1'b1);
    cyc("R10", '0, 1'b1, 2'd0, 4'b0011, 1'b0);  // block lower sources
    cyc("R3", '0, 1'b1, 2'd1, 4'b0001, 1'b0);
    idle("R3", 2);
    cyc("R3", '0, 1'b0, 2'd3, '0, 1'b1);
    // R9: clear while request held keeps the bit
    cyc("R9", 4'b0001, 1'b1, 2'd0, 4'b1111, 1'b0);
    cyc("R9", 4'b0001, 1'b1, 2'd2, 4'b0001, 1'b0);
    cyc("R9", '0, 1'b0, 2'd3, '0, 1'b1);
    cyc("R9", '0, 1'b1, 2'd2, 4'b1111, 1'b0);
    idle("R9", 2);
    cyc("R9", '0, 1'b0, 2'd3, '0, 1'b1);
    // R7: ack beats a same-cycle enable write
    cyc("R7", 4'b1000, 1'b1, 2'd1, 4'b0001, 1'b0);
    idle("R7", 2);
    cyc("R7", '0, 1'b1, 2'd1, 4'b0001, 1'b1);
    idle("R7", 2);
    // R10: reserved select leaves state alone
    cyc("R10", '0, 1'b1, 2'd3, 4'b0000, 1'b0);
    cyc("R10", '0, 1'b0, 2'd3, '0, 1'b1);
    cyc("R8", '0, 1'b1, 2'd1, 4'b0000, 1'b0);
    idle("R8", 2);

    // pseudo-random stretch
    lfsr = 8'hA5;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc("R4", (lfsr[2:0] == 3'd0) ? lfsr[7:4] : 4'b0000, lfsr[3] & lfsr[1],
          lfsr[5:4], lfsr[7:4] ^ lfsr[3:0], (lfsr[6:5] == 2'b11));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule